// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash device and works out when an internal program or erase inside that device has finished. A one-cycle start pulse hands it the polling mode, the kind of operation, the target address, the byte that was written and a limit on status reads. The controller then issues status reads on a simple synchronous read bus. Each read is a request held until the device returns data with a valid strobe. The controller checks the returned bytes until it sees completion or runs out of attempts.

Two polling methods are offered. In toggle mode the controller compares bit 6 of each status byte with bit 6 of the read just before it. Equal values mean the device has stopped toggling. In data-bit-7 mode the controller watches bit 7 of each status read against the value that completion implies. Bit 7 can settle before the lower bits are valid, so after completion the controller does one more separate read at the same address. It returns that byte as the final data, together with a done pulse. If the read limit runs out first, done pulses with an error flag and no extra read is made.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the block is idle: busy, rd_req, done and error are all 0.
- R2: start is accepted only while busy is 0. A start pulse during an operation changes neither the address being read nor the result of the operation in progress.
- R3: Each read holds rd_req at 1 with rd_addr equal to the start address, unchanged, until rd_valid is 1. In the cycle after a read completes, rd_req is 0, so every read is a separate bus cycle.
- R4: With mode=0 (toggle polling), the first status byte is only stored. A later status byte signals completion when its bit 6 equals bit 6 of the status byte read just before it. Changes in the other bits have no effect.
- R5: With mode=1 (data-bit-7 polling) and op_type=0 (program), a status byte signals completion when its bit 7 equals bit 7 of exp_data.
- R6: With mode=1 and op_type=1 (erase), a status byte signals completion when its bit 7 is 1, whatever the value of exp_data.
- R7: Once completion is seen, exactly one further read is made at the same address. Its byte appears on final_data, and done pulses with error=0.
- R8: If max_polls status reads complete without a completion (at least one read is always made), done pulses with error=1 and no further read is made. final_data then holds the last status byte.
- R9: done and error are single-cycle pulses. busy is 0 in the cycle in which done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (ignored while busy) |
| mode | input | 1 | 0 = toggle-bit polling, 1 = data-bit-7 polling |
| op_type | input | 1 | 0 = program, 1 = erase |
| addr | input | ADDR_W | Address for every status and final read |
| exp_data | input | 8 | Byte that was programmed (bit 7 used) |
| max_polls | input | CNT_W | Maximum number of status reads |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Read data from the device |
| rd_valid | input | 1 | rd_data valid, completes the current read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | With done: read limit reached |
| final_data | output | 8 | Confirmed byte, or last status byte on error |

## Verification
The assertions assume that rd_valid is 1 only while rd_req is 1, and only for one cycle per request. They also assume that rd_data means something only in that cycle. The bench keeps to this with a device model that answers each held request once, after a set latency, and then drops rd_valid. It varies the latency between operations and takes each byte from a scripted queue. A start pulse during an operation is given only while busy is 1, and the model records every address it is asked for, so a stray new address shows up as a mismatch.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    localparam int TOGGLE_BIT = 6;
    localparam int POLL_BIT   = 7;

    typedef enum logic {
        POLL_TOGGLE = 1'b0,
        POLL_DQ7    = 1'b1
    } poll_mode_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT_RD,
        ST_STAT_GAP,
        ST_CONF_GAP,
        ST_CONF_RD
    } fsm_e;

    typedef struct packed {
        poll_mode_e mode;
        op_kind_e   op;
        logic       exp7;
    } job_cfg_t;

    function automatic logic toggle_settled(input logic [7:0] prev_b, input logic [7:0] cur_b);
        return prev_b[TOGGLE_BIT] == cur_b[TOGGLE_BIT];
    endfunction

    function automatic logic dq7_settled(input job_cfg_t cfg, input logic [7:0] cur_b);
        if (cfg.op == OP_ERASE)
            return cur_b[POLL_BIT];
        return cur_b[POLL_BIT] == cfg.exp7;
    endfunction

endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge
    import fpoll_pkg::*;
(
    input  job_cfg_t   cfg,
    input  logic       have_prev,
    input  logic [7:0] prev_byte,
    input  logic [7:0] cur_byte,
    output logic       complete
);

    always_comb begin
        case (cfg.mode)
            POLL_TOGGLE: complete = have_prev && toggle_settled(prev_byte, cur_byte);
            POLL_DQ7:    complete = dq7_settled(cfg, cur_byte);
            default:     complete = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpoll_counter.sv
module fpoll_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic [EXT_W-1:0] next_ext;

    assign next_ext = {1'b0, count_q} + EXT_W'(1);
    assign last     = next_ext >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr)
            count_q <= '0;
        else if (inc)
            count_q <= next_ext[CNT_W-1:0];
    end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import fpoll_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic              op_type,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        exp_data,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [7:0]        final_data
);

    fsm_e              state_q;
    job_cfg_t          cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  limit_q;
    logic [7:0]        prev_q;
    logic              have_prev_q;
    logic              done_q;
    logic              err_q;
    logic [7:0]        final_q;
    logic              complete;
    logic              last_poll;
    logic              accept;
    logic              stat_miss;

    assign accept    = (state_q == ST_IDLE) && start;
    assign stat_miss = (state_q == ST_STAT_RD) && rd_valid && !complete;

    fpoll_judge u_judge (
        .cfg       (cfg_q),
        .have_prev (have_prev_q),
        .prev_byte (prev_q),
        .cur_byte  (rd_data),
        .complete  (complete)
    );

    fpoll_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (stat_miss),
        .limit (limit_q),
        .last  (last_poll)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            addr_q      <= '0;
            limit_q     <= '0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            final_q     <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q.mode  <= poll_mode_e'(mode);
                        cfg_q.op    <= op_kind_e'(op_type);
                        cfg_q.exp7  <= exp_data[POLL_BIT];
                        addr_q      <= addr;
                        limit_q     <= max_polls;
                        have_prev_q <= 1'b0;
                        state_q     <= ST_STAT_RD;
                    end
                end
                ST_STAT_RD: begin
                    if (rd_valid) begin
                        if (complete) begin
                            state_q <= ST_CONF_GAP;
                        end else if (last_poll) begin
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            final_q <= rd_data;
                            state_q <= ST_IDLE;
                        end else begin
                            prev_q      <= rd_data;
                            have_prev_q <= 1'b1;
                            state_q     <= ST_STAT_GAP;
                        end
                    end
                end
                ST_STAT_GAP: state_q <= ST_STAT_RD;
                ST_CONF_GAP: state_q <= ST_CONF_RD;
                ST_CONF_RD: begin
                    if (rd_valid) begin
                        final_q <= rd_data;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req     = (state_q == ST_STAT_RD) || (state_q == ST_CONF_RD);
    assign rd_addr    = addr_q;
    assign busy       = state_q != ST_IDLE;
    assign done       = done_q;
    assign error      = err_q;
    assign final_data = final_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R3
    AST_READ_GAP: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_valid |=> !rd_req); // R3
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(rd_addr)); // R2
    AST_CONFIRM_OK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONF_RD) && rd_valid |=> done && !error); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        error |-> done && !busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_TOGGLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        complete && (cfg_q.mode == POLL_TOGGLE) |-> have_prev_q); // R4

endmodule

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;

    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;

    typedef struct {
        logic       err;
        logic [7:0] fin;
        int         reads;
        string      tag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic              op_type = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        exp_data = '0;
    logic [CNT_W-1:0]  max_polls = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data = '0;
    logic              rd_valid = 1'b0;
    logic              busy;
    logic              done;
    logic              error;
    logic [7:0]        final_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]        resp_q[$];
    exp_item_t         exp_q[$];
    int                lat = 0;
    int                wait_c = 0;
    int                total_reads = 0;
    int                base_reads = 0;
    logic [ADDR_W-1:0] cur_addr = '0;
    logic              last_valid = 1'b0;
    logic              done_seen = 1'b0;

    always #2 clk = ~clk;

    flash_poll_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_flash_poll_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .op_type(op_type),
        .addr(addr), .exp_data(exp_data), .max_polls(max_polls),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .error(error), .final_data(final_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Device model: answers each held request once after lat cycles.
    always @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            wait_c     <= 0;
            last_valid <= 1'b0;
        end else begin
            last_valid <= rd_valid;
            if (last_valid)
                check(!rd_req, "R3", "rd_req after completed read", int'(rd_req), 0);
            if (rd_valid) begin
                rd_valid <= 1'b0;
            end else if (rd_req) begin
                if (wait_c >= lat) begin
                    wait_c <= 0;
                    check(rd_addr == cur_addr, "R3", "rd_addr", int'(rd_addr), int'(cur_addr));
                    total_reads <= total_reads + 1;
                    rd_valid <= 1'b1;
                    if (resp_q.size() > 0) rd_data <= resp_q.pop_front();
                    else rd_data <= 8'h00;
                end else begin
                    wait_c <= wait_c + 1;
                end
            end
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done_seen)
                check(!done, "R9", "done width", int'(done), 0);
            done_seen <= done;
            if (done) begin
                exp_item_t e;
                check(!busy, "R9", "busy with done", int'(busy), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(error == e.err, e.tag, "error", int'(error), int'(e.err));
                    check(final_data == e.fin, e.tag, "final_data", int'(final_data), int'(e.fin));
                    check(total_reads - base_reads == e.reads, e.tag, "read count",
                          total_reads - base_reads, e.reads);
                end
            end
        end
    end

    task automatic run_op(input logic m, input logic op, input logic [ADDR_W-1:0] a,
                          input logic [7:0] ex, input int maxp, input int latency,
                          input logic [7:0] bytes[$], input logic exp_err,
                          input logic [7:0] exp_fin, input int exp_reads,
                          input string tag, input bit poke);
        exp_item_t e;
        @(negedge clk);
        lat = latency;
        foreach (bytes[i]) resp_q.push_back(bytes[i]);
        e.err = exp_err; e.fin = exp_fin; e.reads = exp_reads; e.tag = tag;
        exp_q.push_back(e);
        base_reads = total_reads;
        cur_addr = a;
        mode = m; op_type = op; addr = a; exp_data = ex; max_polls = CNT_W'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            check(busy, "R2", "busy before stray start", int'(busy), 1);
            mode = ~m; op_type = ~op; addr = a ^ 24'h000FFF; exp_data = ~ex; max_polls = 1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        check(resp_q.size() == 0, tag, "unused responses", resp_q.size(), 0);
        resp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rd_req && !done && !error, "R1", "idle after reset",
              {busy, rd_req, done, error}, 0);

        // R4: bit 6 pattern 1,0,1,1 with other bits changing; confirm byte 5A
        run_op(1'b0, 1'b0, 24'h012345, 8'h00, 10, 0,
               '{8'h40, 8'h03, 8'h7F, 8'h44, 8'h5A}, 1'b0, 8'h5A, 5, "R4", 1'b0);
        // R4 and R7: two equal reads settle at once
        run_op(1'b0, 1'b1, 24'h000010, 8'hFF, 10, 2,
               '{8'h00, 8'h00, 8'h11}, 1'b0, 8'h11, 3, "R7", 1'b0);
        // R5: program, expected bit 7 = 1
        run_op(1'b1, 1'b0, 24'h0ABCDE, 8'h80, 10, 1,
               '{8'h00, 8'h7F, 8'h80, 8'hC3}, 1'b0, 8'hC3, 4, "R5", 1'b0);
        // R5: program, expected bit 7 = 0
        run_op(1'b1, 1'b0, 24'h0ABCDF, 8'h00, 10, 0,
               '{8'h80, 8'hFF, 8'h01, 8'h22}, 1'b0, 8'h22, 4, "R5", 1'b0);
        // R6: erase ignores exp_data; 00 would settle a program with exp bit7 = 0
        run_op(1'b1, 1'b1, 24'h100000, 8'h00, 10, 0,
               '{8'h00, 8'h7F, 8'hFF, 8'hFF}, 1'b0, 8'hFF, 4, "R6", 1'b0);
        // R8: toggle timeout after 3 reads
        run_op(1'b0, 1'b0, 24'h000777, 8'h00, 3, 1,
               '{8'h00, 8'h40, 8'h00}, 1'b1, 8'h00, 3, "R8", 1'b0);
        // R8: erase timeout after 2 reads
        run_op(1'b1, 1'b1, 24'h000888, 8'h00, 2, 0,
               '{8'h00, 8'h10}, 1'b1, 8'h10, 2, "R8", 1'b0);
        // R8: limit 0 still makes one read
        run_op(1'b1, 1'b0, 24'h000999, 8'h80, 0, 0,
               '{8'h33}, 1'b1, 8'h33, 1, "R8", 1'b0);
        // R2: stray start while busy is ignored
        run_op(1'b0, 1'b0, 24'h0F0F0F, 8'h00, 10, 2,
               '{8'h40, 8'h00, 8'h00, 8'h9C}, 1'b0, 8'h9C, 4, "R2", 1'b1);
        repeat (4) @(negedge clk);
        check(!busy && !rd_req, "R2", "idle after op", {busy, rd_req}, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule